// File: doc/BRIEF.md
# Register Rename Map with Free List

This block sits in the dispatch stage of an out-of-order core. Each cycle it takes a group of up to `GW` micro-ops, each naming two architected source registers and, optionally, one architected destination. For every source it returns the physical register that currently holds the newest value of that architected register. For every destination it hands out a fresh physical register. Two micro-ops that write the same architected register therefore never have to wait for each other.

Two copies of the map are kept. The speculative map follows renaming. The committed map follows in-order completion. When a micro-op completes, its new physical register becomes the committed home of its destination, and the physical register that was committed there before goes back to the free list. Architected state therefore changes only at completion. A flush throws away everything in flight: the speculative map is overwritten with the committed map, and the free list is recomputed as every pool entry that the committed map does not use.

The physical file holds `NPHYS` registers. The top `NRESV` indices are set aside for a save register and for scratch registers that only cracked micro-ops can reach. The rename pool is the rest.

Top module: `reg_rename`

## Requirements
- R1: After reset, architected register i reads as physical register i on every source lookup.
- R2: Destinations in an accepted group receive the lowest-numbered free pool entries, assigned in increasing slot order. With the defaults (32 architected, 80 physical, 5 reserved), pool entries 32 to 74 are free after reset, and the first destination gets 32.
- R3: Physical indices from NPHYS-NRESV to NPHYS-1 (75 to 79 by default) are never handed out as destinations.
- R4: `grp_ready` is low when the free list holds fewer entries than the number of slots with both `grp_valid` and `grp_has_dst` set. A group that is not accepted changes neither map nor the free list.
- R5: A source in slot k whose architected index equals the destination of an earlier destination-writing slot in the same group gets that slot's new physical index; when several match, the nearest earlier slot wins. Otherwise the source gets the speculative map entry.
- R6: When several slots of one group write the same architected register, the speculative map keeps the last slot's allocation.
- R7: A completion (`cmt_valid`, `cmt_arch`, `cmt_phys`) sets the committed map entry and frees the previous committed mapping. The freed entry can be allocated from the next cycle, not in the completion cycle.
- R8: While `flush` is high, `grp_ready` is low. After the flush edge, the speculative map equals the committed map, including a completion in the same cycle, and the free list is every pool entry that the committed map does not hold.
- R9: A slot without a destination shows physical index 0 on its `out_dst` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard in-flight state, restore from committed map |
| grp_valid | input | GW | Per-slot micro-op present |
| grp_has_dst | input | GW | Per-slot destination present |
| grp_dst | input | GW*AW | Per-slot architected destination, slot k at bits k*AW |
| grp_src_a | input | GW*AW | Per-slot first architected source |
| grp_src_b | input | GW*AW | Per-slot second architected source |
| grp_ready | output | 1 | Group accepted this cycle |
| out_src_a | output | GW*PW | Physical index for first source |
| out_src_b | output | GW*PW | Physical index for second source |
| out_dst | output | GW*PW | Newly allocated physical destination |
| cmt_valid | input | 1 | One micro-op completes this cycle |
| cmt_arch | input | AW | Architected destination of completing micro-op |
| cmt_phys | input | PW | Physical register it was given at rename |

## Verification
Completion can land in the same cycle as either of the other two functions. When it meets a rename group, the bench first drains the free list to zero and then presents a one-destination group together with a completion. That group must stall, and the freed index must come back on the very next group. When it meets a flush, the restored speculative map must already include that completion, and the rebuilt free list must leave out its new index. The bench judges both cases by sweeping every source afterwards and by watching which indices the next allocations return.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int unsigned RN_NARCH = 32;
  parameter int unsigned RN_NPHYS = 80;
  parameter int unsigned RN_NRESV = 5;
  parameter int unsigned RN_GW    = 2;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int unsigned NPHYS = 80,
  parameter int unsigned POOL  = 75,
  parameter int unsigned NARCH = 32,
  parameter int unsigned GW    = 2,
  parameter int unsigned PW    = $clog2(NPHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GW-1:0]          want,
  input  logic                   take,
  input  logic                   rel_valid,
  input  logic [PW-1:0]          rel_idx,
  input  logic                   rebuild,
  input  logic [NPHYS-1:0]       rebuild_used,
  output logic [GW-1:0][PW-1:0]  grant,
  output logic                   enough
);
  localparam int unsigned CW = $clog2(NPHYS + 1);

  function automatic logic [CW-1:0] bits_set(input logic [NPHYS-1:0] v);
    logic [CW-1:0] n = '0;
    for (int i = 0; i < NPHYS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  function automatic logic [CW-1:0] slots_set(input logic [GW-1:0] v);
    logic [CW-1:0] n = '0;
    for (int i = 0; i < GW; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  function automatic logic [NPHYS-1:0] band(input int unsigned lo, input int unsigned hi);
    logic [NPHYS-1:0] m = '0;
    for (int i = 0; i < NPHYS; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

  localparam logic [NPHYS-1:0] POOL_MASK  = band(0, POOL);
  localparam logic [NPHYS-1:0] RESET_FREE = band(NARCH, POOL);

  logic [NPHYS-1:0] free_q, free_d, avail;
  logic             hit;

  always_comb begin
    avail = free_q;
    hit   = 1'b0;
    for (int k = 0; k < GW; k++) begin
      grant[k] = '0;
      hit      = 1'b0;
      for (int p = 0; p < POOL; p++) begin
        if (!hit && avail[p]) begin
          grant[k] = PW'(p);
          hit      = 1'b1;
        end
      end
      if (want[k] && hit) avail[grant[k]] = 1'b0;
    end
  end

  assign enough = bits_set(free_q) >= slots_set(want);

  always_comb begin
    if (rebuild) begin
      free_d = POOL_MASK & ~rebuild_used;
    end else begin
      free_d = take ? avail : free_q;
      if (rel_valid) free_d[rel_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= RESET_FREE;
    else        free_q <= free_d;
  end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int unsigned NARCH = 32,
  parameter int unsigned NPHYS = 80,
  parameter int unsigned GW    = 2,
  parameter int unsigned AW    = $clog2(NARCH),
  parameter int unsigned PW    = $clog2(NPHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [GW-1:0]            wr_en,
  input  logic [GW-1:0][AW-1:0]    wr_arch,
  input  logic [GW-1:0][PW-1:0]    wr_phys,
  input  logic                     flush,
  input  logic                     cm_valid,
  input  logic [AW-1:0]            cm_arch,
  input  logic [PW-1:0]            cm_phys,
  output logic [NARCH-1:0][PW-1:0] spec_map,
  output logic [PW-1:0]            cm_old,
  output logic [NPHYS-1:0]         cm_used_next
);
  logic [NARCH-1:0][PW-1:0] spec_q, spec_d, cmt_q, cmt_d;

  always_comb begin
    cmt_d = cmt_q;
    if (cm_valid) cmt_d[cm_arch] = cm_phys;
  end

  always_comb begin
    if (flush) begin
      spec_d = cmt_d;
    end else begin
      spec_d = spec_q;
      for (int k = 0; k < GW; k++)
        if (wr_en[k]) spec_d[wr_arch[k]] = wr_phys[k];
    end
  end

  always_comb begin
    cm_used_next = '0;
    for (int a = 0; a < NARCH; a++) cm_used_next[cmt_d[a]] = 1'b1;
  end

  assign spec_map = spec_q;
  assign cm_old   = cmt_q[cm_arch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NARCH; a++) begin
        spec_q[a] <= PW'(a);
        cmt_q[a]  <= PW'(a);
      end
    end else begin
      spec_q <= spec_d;
      cmt_q  <= cmt_d;
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rn_pkg::*;
#(
  parameter int unsigned NARCH = RN_NARCH,
  parameter int unsigned NPHYS = RN_NPHYS,
  parameter int unsigned NRESV = RN_NRESV,
  parameter int unsigned GW    = RN_GW,
  parameter int unsigned AW    = $clog2(NARCH),
  parameter int unsigned PW    = $clog2(NPHYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [GW-1:0]    grp_valid,
  input  logic [GW-1:0]    grp_has_dst,
  input  logic [GW*AW-1:0] grp_dst,
  input  logic [GW*AW-1:0] grp_src_a,
  input  logic [GW*AW-1:0] grp_src_b,
  output logic             grp_ready,
  output logic [GW*PW-1:0] out_src_a,
  output logic [GW*PW-1:0] out_src_b,
  output logic [GW*PW-1:0] out_dst,
  input  logic             cmt_valid,
  input  logic [AW-1:0]    cmt_arch,
  input  logic [PW-1:0]    cmt_phys
);
  localparam int unsigned POOL = NPHYS - NRESV;

  logic [GW-1:0][AW-1:0]    dst_a, srca_a, srcb_a;
  logic [GW-1:0][PW-1:0]    grant, srca_p, srcb_p, dst_p;
  logic [GW-1:0]            want, wr_fire;
  logic [NARCH-1:0][PW-1:0] spec_map;
  logic [PW-1:0]            cm_old;
  logic [NPHYS-1:0]         cm_used_next;
  logic                     enough;

  assign dst_a  = grp_dst;
  assign srca_a = grp_src_a;
  assign srcb_a = grp_src_b;
  assign want   = grp_valid & grp_has_dst;

  assign grp_ready = !flush && enough;
  assign wr_fire   = want & {GW{grp_ready}};

  rn_freelist #(.NPHYS(NPHYS), .POOL(POOL), .NARCH(NARCH), .GW(GW), .PW(PW)) u_free (
    .clk(clk), .rst_n(rst_n), .want(want), .take(grp_ready),
    .rel_valid(cmt_valid), .rel_idx(cm_old),
    .rebuild(flush), .rebuild_used(cm_used_next),
    .grant(grant), .enough(enough)
  );

  rn_maptable #(.NARCH(NARCH), .NPHYS(NPHYS), .GW(GW), .AW(AW), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_arch(dst_a), .wr_phys(grant),
    .flush(flush), .cm_valid(cmt_valid), .cm_arch(cmt_arch), .cm_phys(cmt_phys),
    .spec_map(spec_map), .cm_old(cm_old), .cm_used_next(cm_used_next)
  );

  always_comb begin
    for (int k = 0; k < GW; k++) begin
      srca_p[k] = spec_map[srca_a[k]];
      srcb_p[k] = spec_map[srcb_a[k]];
      for (int j = 0; j < k; j++) begin
        if (want[j] && dst_a[j] == srca_a[k]) srca_p[k] = grant[j];
        if (want[j] && dst_a[j] == srcb_a[k]) srcb_p[k] = grant[j];
      end
      dst_p[k] = want[k] ? grant[k] : '0;
    end
  end

  assign out_src_a = srca_p;
  assign out_src_b = srcb_p;
  assign out_dst   = dst_p;
endmodule

// File: rtl/rn_chk.sv
module rn_chk #(
  parameter int unsigned GW   = 2,
  parameter int unsigned AW   = 5,
  parameter int unsigned PW   = 7,
  parameter int unsigned POOL = 75
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  grp_ready,
  input logic [GW-1:0]         want,
  input logic [GW-1:0][AW-1:0] dst_arch,
  input logic [GW-1:0][AW-1:0] src_arch,
  input logic [GW-1:0][PW-1:0] dst_phys,
  input logic [GW-1:0][PW-1:0] src_phys
);
  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !grp_ready);

  for (genvar k = 0; k < GW; k++) begin : g_slot
    a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_ready && want[k]) |-> (dst_phys[k] < PW'(POOL)));
  end

  if (GW >= 2) begin : g_pair
    a_r2_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_ready && want[0] && want[1]) |-> (dst_phys[0] != dst_phys[1]));
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_ready && want[0] && src_arch[1] == dst_arch[0]) |-> (src_phys[1] == dst_phys[0]));
    a_r2_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_ready && want[0] && want[1]) |-> (src_phys[0] != dst_phys[1] || src_phys[0] != dst_phys[0]));
  end
endmodule

bind reg_rename rn_chk #(.GW(GW), .AW(AW), .PW(PW), .POOL(POOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .grp_ready(grp_ready),
  .want(want), .dst_arch(dst_a), .src_arch(srca_a),
  .dst_phys(dst_p), .src_phys(srca_p)
);

// File: tb/sim_reg_rename.sv
module sim_reg_rename;
  localparam int CLK_P = 10;
  localparam int GW = 2, AW = 5, PW = 7, NA = 32, POOLN = 75;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, cmt_valid = 1'b0, grp_ready;
  logic [GW-1:0] grp_valid = '0, grp_has_dst = '0;
  logic [GW*AW-1:0] grp_dst = '0, grp_src_a = '0, grp_src_b = '0;
  logic [GW*PW-1:0] out_src_a, out_src_b, out_dst;
  logic [AW-1:0] cmt_arch = '0;
  logic [PW-1:0] cmt_phys = '0;

  always #(CLK_P/2) clk = ~clk;

  reg_rename u0 (.clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
    .grp_has_dst(grp_has_dst), .grp_dst(grp_dst), .grp_src_a(grp_src_a),
    .grp_src_b(grp_src_b), .grp_ready(grp_ready), .out_src_a(out_src_a),
    .out_src_b(out_src_b), .out_dst(out_dst), .cmt_valid(cmt_valid),
    .cmt_arch(cmt_arch), .cmt_phys(cmt_phys));

  int vectors = 0, miss = 0;
  int smap[NA], cmap[NA];
  bit fr[80];
  int qa[256], qp[256];
  int qh = 0, qt = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input bit fl, input bit [1:0] v, input bit [1:0] hd,
                      input int d0, input int d1, input int a0, input int a1,
                      input int b0, input int b1, input bit cm, input string tag);
    int d[2], a[2], b[2], g[2];
    bit need[2], tmp[80], cm_eff, rdy;
    int nfree, ncnt, ea, eb, ed, old;
    d[0] = d0; d[1] = d1; a[0] = a0; a[1] = a1; b[0] = b0; b[1] = b1;
    @(negedge clk);
    cm_eff = cm && (qh != qt);
    flush = fl; grp_valid = v; grp_has_dst = hd;
    for (int k = 0; k < 2; k++) begin
      grp_dst[k*AW +: AW] = AW'(d[k]);
      grp_src_a[k*AW +: AW] = AW'(a[k]);
      grp_src_b[k*AW +: AW] = AW'(b[k]);
    end
    cmt_valid = cm_eff;
    cmt_arch = AW'(qa[qh % 256]);
    cmt_phys = PW'(qp[qh % 256]);
    #1;
    nfree = 0; ncnt = 0;
    for (int p = 0; p < POOLN; p++) nfree += fr[p];
    for (int k = 0; k < 2; k++) begin need[k] = v[k] & hd[k]; ncnt += need[k]; end
    rdy = !fl && (nfree >= ncnt);
    tmp = fr;
    for (int k = 0; k < 2; k++) begin
      g[k] = 0;
      for (int p = 0; p < POOLN; p++) if (tmp[p]) begin g[k] = p; break; end
      if (need[k]) tmp[g[k]] = 1'b0;
    end
    chk(grp_ready == rdy, fl ? "R8" : "R4", int'(grp_ready), int'(rdy));
    if (rdy) begin
      for (int k = 0; k < 2; k++) begin
        ed = need[k] ? g[k] : 0;
        chk(int'(out_dst[k*PW +: PW]) == ed, need[k] ? "R2" : "R9", int'(out_dst[k*PW +: PW]), ed);
        if (need[k]) chk(int'(out_dst[k*PW +: PW]) < POOLN, "R3", int'(out_dst[k*PW +: PW]), POOLN - 1);
        ea = smap[a[k]]; eb = smap[b[k]];
        for (int j = 0; j < k; j++) begin
          if (need[j] && d[j] == a[k]) ea = g[j];
          if (need[j] && d[j] == b[k]) eb = g[j];
        end
        chk(int'(out_src_a[k*PW +: PW]) == ea, (k > 0 && need[0] && d[0] == a[k]) ? "R5" : tag,
            int'(out_src_a[k*PW +: PW]), ea);
        chk(int'(out_src_b[k*PW +: PW]) == eb, tag, int'(out_src_b[k*PW +: PW]), eb);
      end
      for (int k = 0; k < 2; k++) if (need[k]) begin
        smap[d[k]] = g[k]; fr[g[k]] = 1'b0;
        qa[qt % 256] = d[k]; qp[qt % 256] = g[k]; qt++;
      end
    end
    if (cm_eff) begin
      old = cmap[qa[qh % 256]];
      cmap[qa[qh % 256]] = qp[qh % 256];
      fr[old] = 1'b1;
      qh++;
    end
    if (fl) begin
      smap = cmap;
      for (int p = 0; p < 80; p++) fr[p] = (p < POOLN);
      for (int r = 0; r < NA; r++) fr[cmap[r]] = 1'b0;
      qt = qh;
    end
  endtask

  task automatic idle_commit(input int n);
    for (int i = 0; i < n; i++) step(0, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 1, "R7");
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NA; i += 2) step(0, 2'b11, 2'b00, 0, 0, i, i + 1, i + 1, i, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    miss++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    for (int r = 0; r < NA; r++) begin smap[r] = r; cmap[r] = r; end
    for (int p = 0; p < 80; p++) fr[p] = (p >= NA && p < POOLN);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity mapping after reset
    sweep("R1");
    // R2, R4: exhaust the pool with two-destination groups
    for (int i = 0; i < 21; i++) step(0, 2'b11, 2'b11, i % NA, (i + 9) % NA, i % NA, 3, 4, 5, 0, "R2");
    step(0, 2'b11, 2'b11, 1, 2, 3, 4, 5, 6, 0, "R4");
    step(0, 2'b01, 2'b01, 8, 0, 8, 0, 1, 1, 0, "R4");
    step(0, 2'b01, 2'b01, 9, 0, 9, 0, 1, 1, 0, "R4");
    // R7: completion with a one-destination group while the pool is empty
    step(0, 2'b01, 2'b01, 9, 0, 9, 0, 1, 1, 1, "R7");
    step(0, 2'b01, 2'b01, 10, 0, 10, 0, 2, 2, 0, "R7");
    idle_commit(30);
    // R6, R5: two writers of one register in one group
    step(0, 2'b11, 2'b11, 7, 7, 3, 7, 1, 7, 0, "R6");
    step(0, 2'b11, 2'b00, 0, 0, 7, 7, 7, 6, 0, "R6");
    // R8: flush together with a completion
    step(1, 2'b11, 2'b11, 4, 5, 1, 2, 3, 4, 1, "R8");
    sweep("R8");
    step(0, 2'b11, 2'b11, 11, 12, 11, 11, 12, 12, 0, "R8");
    idle_commit(4);
    step(1, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R8");
    sweep("R8");
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 60) == 0, 2'($urandom), 2'($urandom), $urandom % NA, $urandom % NA,
           $urandom % NA, $urandom % NA, $urandom % NA, $urandom % NA, ($urandom % 3) != 0, "R5");
    end
    idle_commit(80);
    sweep("R7");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule